// File: doc/BRIEF.md
# Latchable Parity Transceiver

This block moves one byte plus a parity bit between two ports, A and B, in either direction. Two active-low direction enables pick the direction. A mode input chooses between two ways of producing the destination parity bit. In the first, parity is recomputed from the source data and replaces the incoming bit. In the second, the incoming bit is passed through unchanged. An odd/even input sets the parity sense. Both ports carry their parity check all the time. Each port raises its own active-low error flag when the parity it sees does not match the data it sees, so a corrupted byte can be flagged on either side while it is in transit.

Each port has a latch stage with its own enable. It is built as a register with a bypass mux, so the block remains synchronous. While the enable is high the stage is transparent: generation and checking use the live value on the bus, and the register follows that value on every clock edge. While the enable is low, generation and checking use the value captured at the last edge on which the enable was high. When a port is being driven, its latch stage sees the driven value. A transparent destination stage therefore checks the byte that was just regenerated or forwarded. Each bus is split into an input, an output and an output-valid signal.

Top module: `lpx_transceiver`

## Requirements
- R1: With `gab_n` low and `gba_n` high, port B is driven (`b_oe`=1, `a_oe`=0). With `gab_n` high and `gba_n` low, port A is driven. With both high, neither port is driven. An undriven port's data and parity outputs read zero.
- R2: With both direction enables low, neither port is driven, and `err_a_n` and `err_b_n` both read 1.
- R3: When `sel_thru` is 0, the destination data equals the source's viewed data, and the destination parity bit is recomputed from that data.
- R4: When `sel_thru` is 1, the destination data and parity bit equal the source's viewed data and parity bit, unchanged.
- R5: The computed parity bit is the XOR of the 8 data bits when `odd_sel` is 0 (even). It is the inverse of that XOR when `odd_sel` is 1 (odd).
- R6: With a port's latch enable at 1, that port uses its live bus value, and its register loads that value at each rising clock edge.
- R7: With a port's latch enable at 0, that port uses the value held from the last rising edge at which the enable was 1. After reset, the held value is all zeros.
- R8: Outside the R2 case, a port's error flag reads 0 exactly when the computed parity of that port's viewed data differs from its viewed parity bit.
- R9: A transparent destination port checks the value being driven onto it. In generate mode its flag therefore stays 1. In feed-through mode the flag reports a bad forwarded parity bit.
- R10: With both direction enables high, each error flag reflects its own port's input or held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gab_n | input | 1 | Active-low enable for the A-to-B direction |
| gba_n | input | 1 | Active-low enable for the B-to-A direction |
| sel_thru | input | 1 | 0 = regenerate parity, 1 = pass parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| lat_a_en | input | 1 | Port A latch transparent when 1 |
| lat_b_en | input | 1 | Port B latch transparent when 1 |
| a_in | input | 8 | Port A data arriving |
| a_par_in | input | 1 | Port A parity arriving |
| a_out | output | 8 | Port A data driven |
| a_par_out | output | 1 | Port A parity driven |
| a_oe | output | 1 | Port A driven |
| b_in | input | 8 | Port B data arriving |
| b_par_in | input | 1 | Port B parity arriving |
| b_out | output | 8 | Port B data driven |
| b_par_out | output | 1 | Port B parity driven |
| b_oe | output | 1 | Port B driven |
| err_a_n | output | 1 | Port A parity error, active low |
| err_b_n | output | 1 | Port B parity error, active low |

## Verification
The pass-through assertion assumes the source latch is transparent, so that the source view equals the live port input. The assertions also assume that the data on a driven port comes from the block and not from the port's own input. The stimulus changes every input only after the falling clock edge, so the latch registers load stable values. Before each checked step it loads a known value with both latches transparent, then either keeps or drops each latch enable. The model's held values therefore come only from edges at which the enable was high.

// File: rtl/lpx_pkg.sv
// Shared types for the latchable parity transceiver.
// Assumes nothing beyond the two active-low direction enables.
package lpx_pkg;

    typedef enum logic [1:0] {
        DIR_OFF   = 2'd0,
        DIR_A2B   = 2'd1,
        DIR_B2A   = 2'd2,
        DIR_CLASH = 2'd3
    } dir_e;

    // Map the two active-low enables to a transfer state
    function automatic dir_e decode_dir(input logic gab_n, input logic gba_n);
        case ({gab_n, gba_n})
            2'b01:   return DIR_A2B;
            2'b10:   return DIR_B2A;
            2'b00:   return DIR_CLASH;
            default: return DIR_OFF;
        endcase
    endfunction

endpackage

// File: rtl/lpx_parity.sv
// Parity bit for a data word. odd_sel=0 gives even parity, 1 gives odd.
// Purely combinational; assumes the width is at least one bit.
module lpx_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic         odd_sel,
    output logic         par
);
    // Reduction XOR, inverted for odd sense
    assign par = (^data) ^ odd_sel;
endmodule

// File: rtl/lpx_side.sv
// One port's latch stage. The register loads the port's bus value
// (driven value when the port is driven, else its input) while le=1.
// src_view feeds the opposite port; chk_view feeds this port's checker.
// Assumes the port is not driven while it is the source side.
module lpx_side #(
    parameter int W  = 8,
    localparam int WW = W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          le,
    input  logic [WW-1:0] raw,
    input  logic [WW-1:0] drive,
    input  logic          driven,
    output logic [WW-1:0] src_view,
    output logic [WW-1:0] chk_view
);
    logic [WW-1:0] held;
    logic [WW-1:0] bus;

    // Value present on the port
    assign bus = driven ? drive : raw;

    // Latch register: follows the bus while transparent
    always_ff @(posedge clk) begin
        if (!rst_n)  held <= '0;
        else if (le) held <= bus;
    end

    // Views chosen by the latch enable
    assign src_view = le ? raw : held;
    assign chk_view = le ? bus : held;

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> (held == $past(bus)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(held));
endmodule

// File: rtl/lpx_path.sv
// One transfer direction: forms the destination word from the source view.
// Generate mode replaces the parity bit; feed-through keeps it.
module lpx_path #(
    parameter int W  = 8,
    localparam int WW = W + 1
) (
    input  logic [WW-1:0] src_view,
    input  logic          sel_thru,
    input  logic          odd_sel,
    output logic [WW-1:0] drive
);
    logic gen_par;

    lpx_parity #(.W(W)) u_gen (
        .data    (src_view[W-1:0]),
        .odd_sel (odd_sel),
        .par     (gen_par)
    );

    // Choose the parity bit that travels with the data
    assign drive = {(sel_thru ? src_view[W] : gen_par), src_view[W-1:0]};
endmodule

// File: rtl/lpx_transceiver.sv
// Latchable parity transceiver top. Decodes direction, builds both
// transfer paths and checks parity on both ports at once.
// Assumes a driven port's input is ignored in favour of the driven value.
module lpx_transceiver #(
    parameter int W  = 8,
    localparam int WW = W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gab_n,
    input  logic         gba_n,
    input  logic         sel_thru,
    input  logic         odd_sel,
    input  logic         lat_a_en,
    input  logic         lat_b_en,
    input  logic [W-1:0] a_in,
    input  logic         a_par_in,
    output logic [W-1:0] a_out,
    output logic         a_par_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    input  logic         b_par_in,
    output logic [W-1:0] b_out,
    output logic         b_par_out,
    output logic         b_oe,
    output logic         err_a_n,
    output logic         err_b_n
);
    import lpx_pkg::*;

    dir_e          dir;
    logic          clash;
    logic [WW-1:0] a_src, a_chk, b_src, b_chk;
    logic [WW-1:0] drv_a, drv_b;
    logic          par_a, par_b;

    // Direction decode
    assign dir   = decode_dir(gab_n, gba_n);
    assign a_oe  = (dir == DIR_B2A);
    assign b_oe  = (dir == DIR_A2B);
    assign clash = (dir == DIR_CLASH);

    lpx_side #(.W(W)) u_side_a (
        .clk (clk), .rst_n (rst_n), .le (lat_a_en),
        .raw ({a_par_in, a_in}), .drive (drv_a), .driven (a_oe),
        .src_view (a_src), .chk_view (a_chk)
    );

    lpx_side #(.W(W)) u_side_b (
        .clk (clk), .rst_n (rst_n), .le (lat_b_en),
        .raw ({b_par_in, b_in}), .drive (drv_b), .driven (b_oe),
        .src_view (b_src), .chk_view (b_chk)
    );

    lpx_path #(.W(W)) u_path_ab (
        .src_view (a_src), .sel_thru (sel_thru), .odd_sel (odd_sel), .drive (drv_b)
    );

    lpx_path #(.W(W)) u_path_ba (
        .src_view (b_src), .sel_thru (sel_thru), .odd_sel (odd_sel), .drive (drv_a)
    );

    lpx_parity #(.W(W)) u_chk_a (.data (a_chk[W-1:0]), .odd_sel (odd_sel), .par (par_a));
    lpx_parity #(.W(W)) u_chk_b (.data (b_chk[W-1:0]), .odd_sel (odd_sel), .par (par_b));

    // Port outputs, zero when undriven
    assign {a_par_out, a_out} = a_oe ? drv_a : '0;
    assign {b_par_out, b_out} = b_oe ? drv_b : '0;

    // Error flags, forced high on contention
    assign err_a_n = clash | (par_a == a_chk[W]);
    assign err_b_n = clash | (par_b == b_chk[W]);

    a_r1_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));
    a_r2_clash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!gab_n && !gba_n) |-> (err_a_n && err_b_n && !a_oe && !b_oe));
    a_r3_gen_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_thru && b_oe) |-> ((^{b_par_out, b_out}) == odd_sel));
    a_r5_gen_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_thru && a_oe) |-> ((^{a_par_out, a_out}) == odd_sel));
    a_r4_thru_b: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_thru && b_oe && lat_a_en) |-> (b_out == a_in && b_par_out == a_par_in));
    a_r9_clean_regen: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_thru && a_oe && lat_a_en) |-> err_a_n);
endmodule

// File: tb/test_lpx_transceiver.sv
module test_lpx_transceiver;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gab_n = 1'b1, gba_n = 1'b1, sel_thru = 1'b0, odd_sel = 1'b0;
    logic lat_a_en = 1'b1, lat_b_en = 1'b1;
    logic [7:0] a_in = '0, b_in = '0;
    logic a_par_in = 1'b0, b_par_in = 1'b0;
    logic [7:0] a_out, b_out;
    logic a_par_out, b_par_out, a_oe, b_oe, err_a_n, err_b_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [8:0] mh_a = '0, mh_b = '0;

    always #2.5 clk = ~clk;

    lpx_transceiver i_lpx_transceiver (
        .clk(clk), .rst_n(rst_n), .gab_n(gab_n), .gba_n(gba_n),
        .sel_thru(sel_thru), .odd_sel(odd_sel),
        .lat_a_en(lat_a_en), .lat_b_en(lat_b_en),
        .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
        .err_a_n(err_a_n), .err_b_n(err_b_n)
    );

    function automatic logic pgen(input logic [7:0] d, input logic odd);
        int n = 0;
        for (int i = 0; i < 8; i++) if (d[i]) n++;
        return logic'(n % 2) ^ odd;
    endfunction

    // Expected values from the current inputs and the model's held words
    logic [8:0] e_a, e_b;
    logic e_aoe, e_boe, e_erra, e_errb, e_clash;
    logic [8:0] e_abus, e_bbus;
    function automatic void model();
        logic [8:0] asrc, bsrc, achk, bchk, adrv, bdrv;
        e_boe   = !gab_n && gba_n;
        e_aoe   = gab_n && !gba_n;
        e_clash = !gab_n && !gba_n;
        asrc = lat_a_en ? {a_par_in, a_in} : mh_a;
        bsrc = lat_b_en ? {b_par_in, b_in} : mh_b;
        bdrv = {sel_thru ? asrc[8] : pgen(asrc[7:0], odd_sel), asrc[7:0]};
        adrv = {sel_thru ? bsrc[8] : pgen(bsrc[7:0], odd_sel), bsrc[7:0]};
        e_a = e_aoe ? adrv : 9'd0;
        e_b = e_boe ? bdrv : 9'd0;
        e_abus = e_aoe ? adrv : {a_par_in, a_in};
        e_bbus = e_boe ? bdrv : {b_par_in, b_in};
        achk = lat_a_en ? e_abus : mh_a;
        bchk = lat_b_en ? e_bbus : mh_b;
        e_erra = e_clash ? 1'b1 : (pgen(achk[7:0], odd_sel) == achk[8]);
        e_errb = e_clash ? 1'b1 : (pgen(bchk[7:0], odd_sel) == bchk[8]);
    endfunction

    // Model latch registers
    always @(posedge clk) begin
        model();
        if (!rst_n) begin
            mh_a <= '0; mh_b <= '0;
        end else begin
            if (lat_a_en) mh_a <= e_abus;
            if (lat_b_en) mh_b <= e_bbus;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string etag(input logic le, input logic is_dest);
        if (e_clash) return "R2";
        if (!e_aoe && !e_boe) return "R10";
        if (is_dest) return le ? "R9" : "R8";
        return le ? "R6" : "R7";
    endfunction

    // Compare all outputs just before the next rising edge
    task automatic compare_all();
        string dtag;
        #2;
        model();
        chk(e_clash ? "R2" : "R1", "oe", {a_oe, b_oe}, {e_aoe, e_boe});
        dtag = sel_thru ? "R4" : (odd_sel ? "R5" : "R3");
        chk(dtag, "a_bus", {a_par_out, a_out}, e_a);
        chk(dtag, "b_bus", {b_par_out, b_out}, e_b);
        chk(etag(lat_a_en, e_aoe), "err_a_n", err_a_n, e_erra);
        chk(etag(lat_b_en, e_boe), "err_b_n", err_b_n, e_errb);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: held words are zero after reset; odd sense flags them
        lat_a_en = 1'b0; lat_b_en = 1'b0; odd_sel = 1'b0;
        compare_all();
        chk("R7", "reset held even err_a_n", err_a_n, 1);
        @(negedge clk); odd_sel = 1'b1;
        compare_all();
        chk("R7", "reset held odd err_b_n", err_b_n, 0);
        for (int dir = 0; dir < 4; dir++)
        for (int s = 0; s < 2; s++)
        for (int o = 0; o < 2; o++)
        for (int la = 0; la < 2; la++)
        for (int lb = 0; lb < 2; lb++)
        for (int inj = 0; inj < 2; inj++) begin
            int k = dir * 32 + s * 16 + o * 8 + la * 4 + lb * 2 + inj;
            // Load phase: both latches transparent, known words
            @(negedge clk);
            {gab_n, gba_n} = 2'(dir);
            sel_thru = s[0]; odd_sel = o[0];
            lat_a_en = 1'b1; lat_b_en = 1'b1;
            a_in = 8'(k * 29 + 3); b_in = 8'(k * 53 + 11);
            a_par_in = pgen(a_in, odd_sel) ^ inj[0];
            b_par_in = pgen(b_in, odd_sel) ^ inj[0];
            compare_all();
            // Checked phase: chosen latch enables, new live words
            @(negedge clk);
            lat_a_en = la[0]; lat_b_en = lb[0];
            a_in = 8'(k * 17 + 90); b_in = 8'(k * 71 + 5);
            a_par_in = pgen(a_in, odd_sel) ^ inj[0];
            b_par_in = pgen(b_in, odd_sel);
            compare_all();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule